// File: doc/BRIEF.md
# Reference-Tracking Operating Mode Controller

This block decides which mode a digital PLL runs in and which of several prioritized input references it follows. An external validator reports which references are usable, and the loop reports whether it is phase locked and whether the chosen reference has gone quiet. The controller uses these flags to move between initial acquisition, a second acquisition mode, locked, loss-of-lock and holdover.

All timing comes from a one-millisecond tick. A programmable window limits each acquisition attempt; software would normally set it to 100000 ticks (100 s) and may set it longer. A fixed qualification time, 2000 ticks by default, governs two things: how long phase lock must hold before locked is declared, and how long no reference may be usable before holdover is entered. When a reference fails, the controller invalidates it and falls back to the best remaining one. In revertive mode it also moves up to a better reference as soon as one becomes usable.

Top module: `clksel_mode_ctrl`

## Requirements
- R1: While reset is asserted and directly after it is released, the state output reads 0 (initial acquisition), the selection reads 0, and both strobes are low. The state encoding is: 0 initial acquisition, 1 second acquisition, 2 locked, 3 loss-of-lock, 4 holdover.
- R2: A reference is usable when its valid flag is high, it has not been invalidated, and its priority field is nonzero. A smaller nonzero field means higher priority. A field of 0 disables the reference. Between equal fields the lower index wins. Reference i owns priority bits [i*PRIO_W +: PRIO_W].
- R3: In states 0, 1 and 3, with the selected reference usable, the state reads 2 one cycle after the QUAL_MS-th consecutive tick with phase lock high. Any cycle with phase lock low restarts the count.
- R4: In locked, a cycle with phase lock low moves the state to 3 on the next cycle.
- R5: In states 0, 1 and 3, an activity alarm while the selected reference is usable pulses inval_o for one cycle with only that reference's bit set. That reference then counts as unusable until its valid flag has been low for at least one cycle.
- R6: In states 0, 1 and 3, if the timeout_ms_i-th tick since entry arrives without lock, lock_alarm_o pulses for one cycle together with the R5 invalidation of the selected reference.
- R7: When the selected reference is invalidated or stops being usable and another reference is usable, the next cycle shows state 1 with the best remaining reference selected.
- R8: When no reference is usable, holdover (4) is entered one cycle after the QUAL_MS-th consecutive tick with none usable. Holdover is never entered in a cycle after any reference was usable.
- R9: With revert_i high in states 0, 1 and 3, a usable reference of strictly higher priority than the selected one causes re-entry to state 1 with that reference selected. With revert_i low, the selection stays.
- R10: In holdover, the cycle after any reference is usable shows state 1 with the highest-priority usable reference selected.
- R11: Timers advance only on cycles with tick_i high. Every change of state or of selection restarts the timeout and both qualification counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_valid_i | input | N_REF | Per-reference valid flags from the validator |
| ref_prio_i | input | N_REF*PRIO_W | Packed priority fields, 0 disables |
| act_alarm_i | input | 1 | Activity alarm for the selected reference |
| phase_lock_i | input | 1 | Phase-lock indication for the selected reference |
| revert_i | input | 1 | Revertive selection enable |
| timeout_ms_i | input | TMR_W | Acquisition window in ticks |
| tick_i | input | 1 | One-millisecond timing tick |
| state_o | output | 3 | Current operating state |
| sel_o | output | SEL_W | Selected reference index |
| lock_alarm_o | output | 1 | One-cycle pulse on acquisition timeout |
| inval_o | output | N_REF | One-cycle one-hot invalidation strobe |

## Verification
A scripted sequence drives the controller through each kind of transition. It starts with no references, which separates the holdover wait from an immediate fall-through. Equal and zero priorities show tie-breaking and disabling. A lock pattern with one dropout shows that qualification restarts rather than accumulates. An alarm followed by a timeout shows that an invalidated reference stays excluded while its valid flag remains high. A valid-flag toggle under both revert settings separates revertive from non-revertive selection, and a sparse tick pattern shows that timers are gated by the tick. A long random stretch of flag changes is then compared against a behavioural model on every clock, which catches wrong orderings between simultaneous events.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  typedef enum logic [2:0] {
    ST_PRELOCK  = 3'd0,
    ST_PRELOCK2 = 3'd1,
    ST_LOCKED   = 3'd2,
    ST_LOSS     = 3'd3,
    ST_HOLD     = 3'd4
  } op_state_e;
endpackage

// File: rtl/clksel_timer.sv
module clksel_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (clr_i)                          cnt_q <= '0;
    else if (en_i && cnt_q != {W{1'b1}})     cnt_q <= cnt_q + 1'b1;
  end

  // hit on the tick that brings the count up to the limit
  assign hit_o = en_i && (({1'b0, cnt_q} + {{W{1'b0}}, 1'b1}) >= {1'b0, limit_i});
endmodule

// File: rtl/clksel_pick.sv
module clksel_pick #(
  parameter  int N_REF  = 4,
  parameter  int PRIO_W = 4,
  localparam int SEL_W  = (N_REF > 1) ? $clog2(N_REF) : 1
) (
  input  logic [N_REF-1:0]        cand_i,
  input  logic [N_REF*PRIO_W-1:0] prio_i,
  output logic                    any_o,
  output logic [SEL_W-1:0]        idx_o,
  output logic [PRIO_W-1:0]       prio_o
);
  logic [PRIO_W-1:0] prio_a [N_REF];

  for (genvar g = 0; g < N_REF; g++) begin : g_unpack
    assign prio_a[g] = prio_i[g*PRIO_W +: PRIO_W];
  end

  // strict compare keeps the lowest index among equals
  always_comb begin
    any_o  = 1'b0;
    idx_o  = '0;
    prio_o = '0;
    for (int i = 0; i < N_REF; i++) begin
      if (cand_i[i] && (!any_o || prio_a[i] < prio_o)) begin
        any_o  = 1'b1;
        idx_o  = SEL_W'(i);
        prio_o = prio_a[i];
      end
    end
  end
endmodule

// File: rtl/clksel_mode_ctrl.sv
module clksel_mode_ctrl
  import clksel_pkg::*;
#(
  parameter  int N_REF   = 4,
  parameter  int PRIO_W  = 4,
  parameter  int TMR_W   = 20,
  parameter  int QUAL_MS = 2000,
  localparam int SEL_W   = (N_REF > 1) ? $clog2(N_REF) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_REF-1:0]        ref_valid_i,
  input  logic [N_REF*PRIO_W-1:0] ref_prio_i,
  input  logic                    act_alarm_i,
  input  logic                    phase_lock_i,
  input  logic                    revert_i,
  input  logic [TMR_W-1:0]        timeout_ms_i,
  input  logic                    tick_i,
  output logic [2:0]              state_o,
  output logic [SEL_W-1:0]        sel_o,
  output logic                    lock_alarm_o,
  output logic [N_REF-1:0]        inval_o
);
  localparam int QUAL_W = $clog2(QUAL_MS + 1);

  op_state_e         state_q, nxt;
  logic [SEL_W-1:0]  sel_q, sel_n, pick_idx;
  logic [N_REF-1:0]  inv_q, eff, sel_mask, cand, inval_n;
  logic [PRIO_W-1:0] prio_a [N_REF];
  logic [PRIO_W-1:0] sel_prio, pick_prio;
  logic              pick_any, sel_ok, in_win, any_eff;
  logic              tmo_hit, lock_hit, nv_hit;
  logic              drop, alarm_n, reselect, take;

  for (genvar g = 0; g < N_REF; g++) begin : g_ref
    assign prio_a[g] = ref_prio_i[g*PRIO_W +: PRIO_W];
    assign eff[g]    = ref_valid_i[g] & ~inv_q[g] & (|prio_a[g]);
  end

  assign sel_mask = N_REF'(1) << sel_q;
  assign sel_ok   = eff[sel_q];
  assign sel_prio = prio_a[sel_q];
  assign any_eff  = |eff;
  assign in_win   = (state_q == ST_PRELOCK) || (state_q == ST_PRELOCK2) ||
                    (state_q == ST_LOSS);
  // outside holdover the current reference is never its own fallback
  assign cand     = eff & ~((state_q != ST_HOLD) ? sel_mask : '0);

  clksel_pick #(.N_REF(N_REF), .PRIO_W(PRIO_W)) u_pick (
    .cand_i (cand),
    .prio_i (ref_prio_i),
    .any_o  (pick_any),
    .idx_o  (pick_idx),
    .prio_o (pick_prio)
  );

  clksel_timer #(.W(TMR_W)) u_tmo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (take),
    .en_i    (in_win & tick_i),
    .limit_i (timeout_ms_i),
    .hit_o   (tmo_hit)
  );

  clksel_timer #(.W(QUAL_W)) u_lock_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (take | ~phase_lock_i),
    .en_i    (in_win & tick_i & phase_lock_i),
    .limit_i (QUAL_W'(QUAL_MS)),
    .hit_o   (lock_hit)
  );

  clksel_timer #(.W(QUAL_W)) u_none_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (take | any_eff),
    .en_i    ((state_q != ST_HOLD) & tick_i & ~any_eff),
    .limit_i (QUAL_W'(QUAL_MS)),
    .hit_o   (nv_hit)
  );

  always_comb begin
    nxt      = state_q;
    sel_n    = sel_q;
    drop     = 1'b0;
    alarm_n  = 1'b0;
    reselect = 1'b0;
    unique case (state_q)
      ST_LOCKED: begin
        if (!phase_lock_i) nxt = ST_LOSS;
        else if (!sel_ok)  reselect = 1'b1;
      end
      ST_PRELOCK, ST_PRELOCK2, ST_LOSS: begin
        if (sel_ok && act_alarm_i) begin
          drop     = 1'b1;
          reselect = 1'b1;
        end else if (sel_ok && lock_hit) begin
          nxt = ST_LOCKED;
        end else if (sel_ok && tmo_hit) begin
          drop     = 1'b1;
          alarm_n  = 1'b1;
          reselect = 1'b1;
        end else if (sel_ok && revert_i && pick_any && pick_prio < sel_prio) begin
          nxt   = ST_PRELOCK2;
          sel_n = pick_idx;
        end else if (!sel_ok) begin
          reselect = 1'b1;
        end
      end
      ST_HOLD: begin
        if (pick_any) begin
          nxt   = ST_PRELOCK2;
          sel_n = pick_idx;
        end
      end
      default: nxt = ST_PRELOCK;
    endcase
    if (reselect) begin
      if (pick_any) begin
        nxt   = ST_PRELOCK2;
        sel_n = pick_idx;
      end else if (nv_hit) begin
        nxt = ST_HOLD;
      end
    end
  end

  assign take    = (nxt != state_q) || (sel_n != sel_q);
  assign inval_n = drop ? sel_mask : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_PRELOCK;
      sel_q        <= '0;
      inv_q        <= '0;
      lock_alarm_o <= 1'b0;
      inval_o      <= '0;
    end else begin
      state_q      <= nxt;
      sel_q        <= sel_n;
      inv_q        <= (inv_q | inval_n) & ref_valid_i;
      lock_alarm_o <= alarm_n;
      inval_o      <= inval_n;
    end
  end

  assign state_o = state_q;
  assign sel_o   = sel_q;

  AST_LOCK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOCKED && !phase_lock_i) |=> (state_q == ST_LOSS)); // R4
  AST_LOCK_NEEDS_PL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_LOCKED && !phase_lock_i) |=> (state_q != ST_LOCKED)); // R3
  AST_INVAL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(inval_o)); // R5
  AST_ALARM_INVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_alarm_o |-> ($countones(inval_o) == 1)); // R6
  AST_NO_HOLD_WITH_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_HOLD && any_eff) |=> (state_q != ST_HOLD)); // R8
  AST_HOLD_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && any_eff) |=> (state_q == ST_PRELOCK2)); // R10
endmodule

// File: tb/clksel_mode_ctrl_test.sv
module clksel_mode_ctrl_test;
  localparam int N  = 4;
  localparam int PW = 4;
  localparam int TW = 12;
  localparam int Q  = 8;
  localparam int TMO = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]    ref_valid_i = '0;
  logic [N*PW-1:0] ref_prio_i  = '0;
  logic            act_alarm_i = 1'b0;
  logic            phase_lock_i = 1'b0;
  logic            revert_i = 1'b0;
  logic [TW-1:0]   timeout_ms_i = TW'(TMO);
  logic            tick_i = 1'b1;
  logic [2:0]      state_o;
  logic [1:0]      sel_o;
  logic            lock_alarm_o;
  logic [N-1:0]    inval_o;

  clksel_mode_ctrl #(.N_REF(N), .PRIO_W(PW), .TMR_W(TW), .QUAL_MS(Q)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ref_valid_i(ref_valid_i), .ref_prio_i(ref_prio_i),
    .act_alarm_i(act_alarm_i), .phase_lock_i(phase_lock_i), .revert_i(revert_i),
    .timeout_ms_i(timeout_ms_i), .tick_i(tick_i), .state_o(state_o), .sel_o(sel_o),
    .lock_alarm_o(lock_alarm_o), .inval_o(inval_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // behavioural reference model
  int m_st, m_sel, m_tmo, m_lk, m_nv, m_alarm, m_inval;
  bit m_inv [N];

  function automatic int pr(int i);
    return int'(ref_prio_i[i*PW +: PW]);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_sel = 0; m_tmo = 0; m_lk = 0; m_nv = 0; m_alarm = 0; m_inval = 0;
    for (int i = 0; i < N; i++) m_inv[i] = 0;
  endtask

  task automatic model_step();
    bit eff [N];
    bit any_eff, sel_ok, win, tk, pl;
    bit thit, lhit, nhit, drop, al, rs, take;
    int bi, bp, ns, nsel;
    any_eff = 0;
    for (int i = 0; i < N; i++) begin
      eff[i] = ref_valid_i[i] && !m_inv[i] && pr(i) != 0;
      if (eff[i]) any_eff = 1;
    end
    sel_ok = eff[m_sel];
    win = (m_st == 0 || m_st == 1 || m_st == 3);
    tk = tick_i; pl = phase_lock_i;
    bi = -1; bp = 0;
    for (int i = 0; i < N; i++)
      if (eff[i] && !(m_st != 4 && i == m_sel) && (bi < 0 || pr(i) < bp)) begin
        bi = i; bp = pr(i);
      end
    thit = win && tk && (m_tmo + 1 >= int'(timeout_ms_i));
    lhit = win && tk && pl && (m_lk + 1 >= Q);
    nhit = (m_st != 4) && tk && !any_eff && (m_nv + 1 >= Q);
    ns = m_st; nsel = m_sel; drop = 0; al = 0; rs = 0;
    if (m_st == 2) begin
      if (!pl) ns = 3;
      else if (!sel_ok) rs = 1;
    end else if (win) begin
      if (sel_ok && act_alarm_i) begin drop = 1; rs = 1; end
      else if (sel_ok && lhit) ns = 2;
      else if (sel_ok && thit) begin drop = 1; al = 1; rs = 1; end
      else if (sel_ok && revert_i && bi >= 0 && bp < pr(m_sel)) begin ns = 1; nsel = bi; end
      else if (!sel_ok) rs = 1;
    end else if (bi >= 0) begin
      ns = 1; nsel = bi;
    end
    if (rs) begin
      if (bi >= 0) begin ns = 1; nsel = bi; end
      else if (nhit) ns = 4;
    end
    take = (ns != m_st) || (nsel != m_sel);
    if (take) begin m_tmo = 0; m_lk = 0; m_nv = 0; end
    else begin
      if (win && tk) m_tmo++;
      if (!pl) m_lk = 0; else if (win && tk) m_lk++;
      if (any_eff) m_nv = 0; else if (m_st != 4 && tk) m_nv++;
    end
    for (int i = 0; i < N; i++)
      m_inv[i] = (m_inv[i] || (drop && i == m_sel)) && ref_valid_i[i];
    m_alarm = al;
    m_inval = drop ? (1 << m_sel) : 0;
    m_st = ns; m_sel = nsel;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(int'(state_o) == m_st, "R3 R4 R8 model state", int'(state_o), m_st);
    chk(int'(sel_o) == m_sel, "R2 R7 R9 model sel", int'(sel_o), m_sel);
    chk(int'(lock_alarm_o) == m_alarm, "R6 model alarm", int'(lock_alarm_o), m_alarm);
    chk(int'(inval_o) == m_inval, "R5 model inval", int'(inval_o), m_inval);
  endtask

  task automatic expect_st(int st, int sel, string tag);
    chk(int'(state_o) == st, tag, int'(state_o), st);
    chk(int'(sel_o) == sel, tag, int'(sel_o), sel);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    model_reset();
    // ref3 disabled, ref1/ref2 tie at 1, ref0 at 3
    ref_prio_i = {4'd0, 4'd1, 4'd1, 4'd3};
    repeat (3) @(negedge clk);
    expect_st(0, 0, "R1 reset state");
    chk(lock_alarm_o == 1'b0 && inval_o == '0, "R1 reset strobes", int'(inval_o), 0);
    rst_ni = 1'b1;

    // no references: holdover after Q ticks
    repeat (Q - 1) cyc();
    expect_st(0, 0, "R8 before holdover");
    cyc();
    expect_st(4, 0, "R8 holdover entry");

    // references appear: tie resolved to ref1
    ref_valid_i = 4'b1111;
    cyc();
    expect_st(1, 1, "R10 R2 holdover exit");

    // lock with one dropout restarting qualification
    phase_lock_i = 1'b1;
    repeat (5) cyc();
    phase_lock_i = 1'b0;
    cyc();
    phase_lock_i = 1'b1;
    repeat (Q - 1) cyc();
    expect_st(1, 1, "R3 restart not yet locked");
    cyc();
    expect_st(2, 1, "R3 locked");

    phase_lock_i = 1'b0;
    cyc();
    expect_st(3, 1, "R4 loss of lock");

    act_alarm_i = 1'b1;
    cyc();
    act_alarm_i = 1'b0;
    expect_st(1, 2, "R5 R7 fallback");
    chk(inval_o == 4'b0010, "R5 inval strobe", int'(inval_o), 2);

    repeat (TMO - 1) cyc();
    expect_st(1, 2, "R6 before timeout");
    chk(lock_alarm_o == 1'b0, "R6 no early alarm", int'(lock_alarm_o), 0);
    cyc();
    expect_st(1, 0, "R6 R5 timeout fallback skips invalidated ref1");
    chk(lock_alarm_o == 1'b1, "R6 alarm pulse", int'(lock_alarm_o), 1);
    chk(inval_o == 4'b0100, "R6 inval strobe", int'(inval_o), 4);

    // re-qualify ref1 with revert off, then on
    ref_valid_i = 4'b1101;
    cyc();
    ref_valid_i = 4'b1111;
    cyc();
    cyc();
    expect_st(1, 0, "R9 non-revertive keeps selection");
    revert_i = 1'b1;
    cyc();
    expect_st(1, 1, "R9 revertive switch");
    revert_i = 1'b0;

    ref_valid_i = 4'b0000;
    repeat (Q - 1) cyc();
    expect_st(1, 1, "R8 waiting");
    cyc();
    expect_st(4, 1, "R8 holdover after loss");

    tick_i = 1'b0;
    repeat (20) cyc();
    ref_valid_i = 4'b1000;
    cyc();
    expect_st(4, 1, "R2 disabled ref ignored");
    ref_valid_i = 4'b1001;
    cyc();
    expect_st(1, 0, "R10 exit to ref0");

    // sparse ticks stretch qualification
    phase_lock_i = 1'b1;
    for (int k = 0; k < Q; k++) begin
      tick_i = 1'b0; cyc(); cyc();
      tick_i = 1'b1; cyc();
      if (k == Q - 2) expect_st(1, 0, "R11 tick gating not yet locked");
    end
    expect_st(2, 0, "R11 locked after gated ticks");

    // random stretch against the model
    tick_i = 1'b1;
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < N; i++)
        if ($urandom_range(31) == 0) ref_valid_i[i] = ~ref_valid_i[i];
      act_alarm_i = ($urandom_range(49) == 0);
      if ($urandom_range(11) == 0) phase_lock_i = ~phase_lock_i;
      if ($urandom_range(199) == 0) revert_i = ~revert_i;
      tick_i = ($urandom_range(3) != 0);
      cyc();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule